// File: doc/BRIEF.md
# Binary Triggered Pipeline Readout

This block is the digital back half of a binary strip readout channel group. Each bunch-crossing clock it takes one comparator bit from each of 128 channels and stores the whole column in a circular 256-column pipeline. A level-1 trigger names the column that lies a programmed number of crossings back. The block copies that column, together with its pipeline address, into a short readout queue.

A serializer empties the queue one frame at a time. Each frame is a fixed 144 bits long: a 16-bit header followed by one bit per channel. The data size never depends on occupancy, so an outside controller can predict the state of every buffer. The header lets that controller see which column was read, whether a trigger was lost, and how many triggers are still waiting. Frames follow one another with no idle cycle while the queue holds entries.

Top module: `binary_trig_readout`

## Requirements
- R1: Every clock after reset, `hits_i` is written into the next pipeline column. The write address starts at 0 after reset and wraps modulo 256. A trigger with latency L (1..255) reads out the hits sampled L clocks before the trigger clock. L = 0 reads the hits sampled 256 clocks before.
- R2: The header's 8-bit address field equals the write address of the trigger clock minus L, modulo 256.
- R3: A frame is exactly 144 serial bits, one per clock. `frame_valid_o` is high on each of them. The first frame bit appears in the second clock after the trigger clock.
- R4: Header layout, sent MSB first: bits 15:14 are the start pattern 2'b11, bits 13:6 the address, bit 5 the overflow flag, bits 4:2 the waiting count, and bits 1:0 are 2'b00.
- R5: The 128 channel bits follow the header directly, channel 0 first and channel 127 last.
- R6: The queue holds 8 triggers. A trigger that arrives while 8 are held is dropped and produces no frame.
- R7: The overflow flag (header bit 5) reads 1 in every frame started after a dropped trigger. Only reset clears it.
- R8: The waiting count is the number of queued triggers left behind the frame as it starts. A trigger accepted in that same clock is not counted.
- R9: While the queue is not empty, one frame follows the previous one with no gap cycle.
- R10: During reset and afterwards until a trigger arrives, `frame_valid_o` and `serial_o` are 0. Reset empties the queue.
- R11: A column yields the same 144-bit frame size whether all hits are set or none is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bunch-crossing clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hits_i | input | 128 | Comparator outputs, bit n is channel n |
| trig_i | input | 1 | Level-1 trigger, one pulse per trigger |
| latency_i | input | 8 | Crossings between the hits and their trigger |
| serial_o | output | 1 | Frame bitstream, MSB of header first |
| frame_valid_o | output | 1 | High while a frame bit is on `serial_o` |

## Verification
The bench builds the block with its defaults: 128 channels, 256 columns and an 8-entry queue. With these values, a ten-trigger burst on consecutive clocks is enough to fill the queue, lose one trigger, and walk the waiting count from 7 down to 0. The depth of 256 brings the wrap cases within a short run: latency 255 and latency 0, which fetches a column one full turn old. Single and paired triggers with all-ones, all-zeros and pseudo-random columns cover the bit order, the fixed frame size and gap-free chaining.

// File: rtl/brt_pkg.sv
package brt_pkg;
  localparam logic [1:0] START_PAT = 2'b11;
  localparam int START_W = 2;
  localparam int PAD_W   = 2;
endpackage

// File: rtl/brt_pipe.sv
module brt_pipe #(
  parameter int NUM_CH = 128,
  parameter int DEPTH  = 256,
  parameter int PTR_W  = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] hits_i,
  input  logic [PTR_W-1:0]  latency_i,
  output logic [PTR_W-1:0]  rd_addr_o,
  output logic [NUM_CH-1:0] rd_col_o
);
  logic [NUM_CH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_ptr_q <= '0;
    else         wr_ptr_q <= wr_ptr_q + PTR_W'(1);
  end

  always_ff @(posedge clk_i) mem_q[wr_ptr_q] <= hits_i;

  // read before write: latency 0 fetches the column one full turn old
  assign rd_addr_o = wr_ptr_q - latency_i;
  assign rd_col_o  = mem_q[rd_addr_o];

  AST_PTR_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ptr_q == '1) |=> (wr_ptr_q == '0)); // R1
endmodule

// File: rtl/brt_queue.sv
module brt_queue #(
  parameter int W     = 136,
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [W-1:0]     data_i,
  input  logic             pop_i,
  output logic [W-1:0]     data_o,
  output logic             empty_o,
  output logic             full_o,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [W-1:0]     buf_q [DEPTH];
  logic [IDX_W-1:0] wr_idx_q, rd_idx_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic             do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = buf_q[rd_idx_q];
  assign count_o = cnt_q;
  assign ovf_o   = ovf_q;

  always_ff @(posedge clk_i) if (do_push) buf_q[wr_idx_q] <= data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_idx_q <= '0;
      rd_idx_q <= '0;
      cnt_q    <= '0;
      ovf_q    <= 1'b0;
    end else begin
      if (do_push) wr_idx_q <= wr_idx_q + IDX_W'(1);
      if (do_pop)  rd_idx_q <= rd_idx_q + IDX_W'(1);
      cnt_q <= cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
      if (push_i && full_o) ovf_q <= 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH)); // R6
  AST_DROP_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i) |=> (cnt_q == $past(cnt_q))); // R6
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o); // R7
  AST_OVF_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> $past(push_i && full_o)); // R7
endmodule

// File: rtl/brt_tx.sv
module brt_tx
  import brt_pkg::*;
#(
  parameter int NUM_CH = 128,
  parameter int PTR_W  = 8,
  parameter int QC_W   = 3,
  parameter int CNT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              q_empty_i,
  input  logic [PTR_W-1:0]  q_addr_i,
  input  logic [NUM_CH-1:0] q_hits_i,
  input  logic [CNT_W-1:0]  q_count_i,
  input  logic              ovf_i,
  output logic              pop_o,
  output logic              serial_o,
  output logic              valid_o
);
  localparam int HDR_W   = START_W + PTR_W + 1 + QC_W + PAD_W;
  localparam int FRAME_W = HDR_W + NUM_CH;
  localparam int BC_W    = $clog2(FRAME_W);

  logic               active_q;
  logic [BC_W-1:0]    bit_cnt_q;
  logic [FRAME_W-1:0] sreg_q;
  logic               last, load;
  logic [QC_W-1:0]    occ;
  logic [HDR_W-1:0]   hdr;
  logic [NUM_CH-1:0]  rev;

  assign last = active_q && (bit_cnt_q == BC_W'(FRAME_W - 1));
  assign load = !q_empty_i && (!active_q || last);
  assign occ  = QC_W'(q_count_i - CNT_W'(1));
  assign hdr  = {START_PAT, q_addr_i, ovf_i, occ, {PAD_W{1'b0}}};

  // channel 0 leaves first, so it sits just below the header
  for (genvar c = 0; c < NUM_CH; c++) begin : g_rev
    assign rev[NUM_CH-1-c] = q_hits_i[c];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q  <= 1'b0;
      bit_cnt_q <= '0;
      sreg_q    <= '0;
    end else if (load) begin
      active_q  <= 1'b1;
      bit_cnt_q <= '0;
      sreg_q    <= {hdr, rev};
    end else if (last) begin
      active_q  <= 1'b0;
      bit_cnt_q <= '0;
    end else if (active_q) begin
      bit_cnt_q <= bit_cnt_q + BC_W'(1);
      sreg_q    <= sreg_q << 1;
    end
  end

  assign pop_o    = load;
  assign serial_o = active_q & sreg_q[FRAME_W-1];
  assign valid_o  = active_q;

  AST_START_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o |=> serial_o); // R4
  AST_FRAME_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(valid_o) |-> ($past(bit_cnt_q) == BC_W'(FRAME_W - 1))); // R3
  AST_NO_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last && !q_empty_i) |=> valid_o); // R9
endmodule

// File: rtl/binary_trig_readout.sv
module binary_trig_readout #(
  parameter int NUM_CH     = 128,
  parameter int PIPE_DEPTH = 256,
  parameter int Q_DEPTH    = 8,
  parameter int PTR_W      = $clog2(PIPE_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] hits_i,
  input  logic              trig_i,
  input  logic [PTR_W-1:0]  latency_i,
  output logic              serial_o,
  output logic              frame_valid_o
);
  localparam int QC_W  = $clog2(Q_DEPTH);
  localparam int CNT_W = $clog2(Q_DEPTH + 1);
  localparam int ENT_W = PTR_W + NUM_CH;

  logic [PTR_W-1:0]  rd_addr;
  logic [NUM_CH-1:0] rd_col;
  logic [ENT_W-1:0]  q_data;
  logic              q_empty, q_full, q_ovf, pop;
  logic [CNT_W-1:0]  q_count;

  brt_pipe #(.NUM_CH(NUM_CH), .DEPTH(PIPE_DEPTH), .PTR_W(PTR_W)) i_pipe (
    .clk_i, .rst_ni, .hits_i, .latency_i,
    .rd_addr_o(rd_addr), .rd_col_o(rd_col)
  );

  brt_queue #(.W(ENT_W), .DEPTH(Q_DEPTH), .CNT_W(CNT_W)) i_queue (
    .clk_i, .rst_ni,
    .push_i(trig_i), .data_i({rd_addr, rd_col}), .pop_i(pop),
    .data_o(q_data), .empty_o(q_empty), .full_o(q_full),
    .count_o(q_count), .ovf_o(q_ovf)
  );

  brt_tx #(.NUM_CH(NUM_CH), .PTR_W(PTR_W), .QC_W(QC_W), .CNT_W(CNT_W)) i_tx (
    .clk_i, .rst_ni,
    .q_empty_i(q_empty), .q_addr_i(q_data[ENT_W-1:NUM_CH]),
    .q_hits_i(q_data[NUM_CH-1:0]), .q_count_i(q_count), .ovf_i(q_ovf),
    .pop_o(pop), .serial_o, .valid_o(frame_valid_o)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_valid_o |-> !serial_o); // R10
  AST_POP_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop |-> !q_empty); // R6
  AST_FULL_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_full |-> (q_count == CNT_W'(Q_DEPTH))); // R6
endmodule

// File: tb/test_binary_trig_readout.sv
`timescale 1ns/1ps
module test_binary_trig_readout;
  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [127:0] hits = '0;
  logic         trig = 1'b0;
  logic [7:0]   latency = '0;
  logic         serial, fvalid;

  binary_trig_readout i_binary_trig_readout (
    .clk_i(clk), .rst_ni(rst_ni), .hits_i(hits), .trig_i(trig),
    .latency_i(latency), .serial_o(serial), .frame_valid_o(fvalid)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int edge_n;
  int mode = 0;
  logic [31:0]  lcg = 32'h1234_5678;
  logic [127:0] hist [0:1023];
  logic [143:0] exp_f [0:15];
  int           exp_n = 0;
  logic [143:0] got_f [0:15];
  int           got_n, nb, valid_total, run, max_run;
  logic [143:0] cur;

  always @(posedge clk or negedge rst_ni)
    if (!rst_ni) edge_n <= 0; else edge_n <= edge_n + 1;

  // hits driver: value set here is sampled at edge edge_n+1
  always @(negedge clk) begin
    logic [127:0] v;
    for (int k = 0; k < 4; k++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      v[k*32 +: 32] = lcg;
    end
    if (mode == 1) v = '1;
    else if (mode == 2) v = '0;
    hits = v;
    hist[(edge_n + 1) % 1024] = v;
  end

  always @(negedge clk) begin
    if (!rst_ni) begin
      got_n = 0; nb = 0; valid_total = 0; run = 0; max_run = 0;
    end else begin
      if (fvalid) begin
        cur = {cur[142:0], serial};
        nb++; valid_total++; run++;
        if (run > max_run) max_run = run;
        if (nb == 144) begin
          if (got_n < 16) got_f[got_n] = cur;
          got_n++; nb = 0;
        end
      end else run = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [143:0] act,
                     input logic [143:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 1'b0; trig = 1'b0; exp_n = 0;
    repeat (3) @(negedge clk);
    chk(!fvalid && !serial, "R10 outputs low in reset", {fvalid, serial}, 0);
    rst_ni = 1'b1;
    repeat (300) @(negedge clk);
    chk(valid_total == 0, "R10 no frame without trigger", valid_total, 0);
  endtask

  // one call = one trigger clock; consecutive calls give consecutive clocks
  task automatic fire(input int lat, input logic [3:0] err, input bit keep);
    int e;
    logic [127:0] d;
    logic [7:0]   a;
    @(negedge clk);
    trig = 1'b1; latency = 8'(lat);
    e = edge_n + 1;
    a = 8'(e - 1 - lat);
    d = hist[(e - ((lat == 0) ? 256 : lat) + 1024) % 1024];
    if (keep) begin
      exp_f[exp_n][143:128] = {2'b11, a, err, 2'b00};
      for (int c = 0; c < 128; c++) exp_f[exp_n][127 - c] = d[c];
      exp_n++;
    end
  endtask

  task automatic release_trig();
    @(negedge clk); trig = 1'b0;
  endtask

  task automatic check_frames(input string req);
    chk(got_n == exp_n, {req, " frame count"}, got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++)
      chk(got_f[i] === exp_f[i], req, got_f[i], exp_f[i]);
  endtask

  task automatic t_single();
    do_reset();
    fire(10, 4'b0000, 1'b1);
    release_trig();
    chk(!fvalid, "R3 no bit in clock after trigger", fvalid, 0);
    @(negedge clk);
    chk(fvalid && serial, "R3 R4 first bit two clocks after trigger", {fvalid, serial}, 2'b11);
    repeat (160) @(negedge clk);
    check_frames("R1 R2 R4 R5 R8 single frame");
    chk(valid_total == 144, "R3 frame length", valid_total, 144);
    chk(!fvalid, "R3 valid low after frame", fvalid, 0);
  endtask

  task automatic t_latencies();
    do_reset();
    @(posedge clk); mode = 1; repeat (4) @(negedge clk);
    fire(1, 4'b0000, 1'b1); release_trig();
    @(posedge clk); mode = 2; repeat (160) @(negedge clk);
    fire(3, 4'b0000, 1'b1); release_trig();
    @(posedge clk); mode = 0; repeat (160) @(negedge clk);
    fire(255, 4'b0000, 1'b1); release_trig();
    repeat (160) @(negedge clk);
    fire(0, 4'b0000, 1'b1); release_trig();
    repeat (160) @(negedge clk);
    check_frames("R1 R2 R5 R11 latency sweep");
    chk(valid_total == 4 * 144, "R11 fixed size for ones and zeros", valid_total, 576);
  endtask

  task automatic t_back_to_back();
    do_reset();
    fire(5, 4'b0000, 1'b1);
    fire(6, 4'b0000, 1'b1);
    release_trig();
    repeat (320) @(negedge clk);
    check_frames("R8 R9 paired frames");
    chk(max_run == 288, "R9 no gap between frames", max_run, 288);
  endtask

  task automatic t_burst();
    do_reset();
    fire(20, 4'b0000, 1'b1);
    for (int k = 0; k < 8; k++) fire(20, {1'b1, 3'(7 - k)}, 1'b1);
    fire(20, 4'b0000, 1'b0); // dropped: queue full
    release_trig();
    repeat (9 * 144 + 40) @(negedge clk);
    check_frames("R6 R7 R8 burst overflow");
    chk(valid_total == 9 * 144, "R6 dropped trigger gives no frame", valid_total, 1296);
  endtask

  task automatic t_reset_clears();
    do_reset();
    fire(7, 4'b0000, 1'b1);
    release_trig();
    repeat (170) @(negedge clk);
    check_frames("R7 R10 overflow cleared by reset");
  endtask

  bit done = 0;

  initial begin
    t_single();
    t_latencies();
    t_back_to_back();
    t_burst();
    t_reset_clears();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule